// File: doc/BRIEF.md
# CAN Frame Field Parser

This block sits behind a bit sampler and destuffer on a CAN receive path. It takes one destuffed frame bit per `bit_vld_i` strobe. It walks the fields of a base-format or extended-format data or remote frame and collects the identifier, the format and remote flags, the length code, up to eight payload bytes, the received 15-bit checksum and the acknowledge slot value. Field positions are not fixed. The IDE bit selects the header layout, and the length code together with the remote flag sets where the checksum, the delimiters and the end-of-frame field fall.

The parsed fields build up in working registers. They are copied to the outputs in the same clock edge that raises `eof_o`, and the outputs then hold until the next frame ends. One-cycle pulses report three conditions: a recessive start bit, a base identifier whose top seven bits are all recessive, and a dominant bit where a delimiter or end-of-frame bit should be recessive. After three intermission bits, `done_o` pulses, the parser goes back to idle and the upstream sampler may hunt for the next start bit.

The control is one state machine. S_IDLE takes the start bit and moves to S_BASE. S_BASE takes 11 identifier bits and moves to S_RTR_SRR. S_RTR_SRR takes one bit and moves to S_IDE. S_IDE moves to S_STD_RB0 when the bit is dominant and to S_EXT_ID when it is recessive. S_STD_RB0 moves to S_DLC. S_EXT_ID takes 18 bits, then S_EXT_RTR, S_EXT_RB1 and S_EXT_RB0 follow, and the machine moves to S_DLC. S_DLC takes 4 bits and moves to S_DATA, or straight to S_CRC when the payload is empty. S_DATA moves to S_CRC after its last payload bit. S_CRC takes 15 bits. S_CRC_DEL, S_ACK and S_ACK_DEL take one bit each. S_EOF takes 7 bits and moves to S_IFS. S_IFS takes 3 bits and moves back to S_IDLE.

Top module: `can_frame_parser`

## Requirements
- R1: After reset every output is 0 and the parser is idle, so the next strobed bit is taken as the start bit.
- R2: Only cycles with `bit_vld_i`=1 consume a bit, and `bit_val_i` is ignored in all other cycles. A start bit that is recessive (1) gives a one-cycle `sof_warn_o` pulse in the cycle after its strobe.
- R3: The base identifier is frame bits 1 to 11, MSB first. When frame bits 1 to 7 (ID[10:4]) are all 1, `id_warn_o` pulses for one cycle in the cycle after the strobe of frame bit 7.
- R4: Frame bit 13 (IDE) = 0 selects the base format. Then `ext_o`=0, `id_o` holds the 11-bit identifier in bits [10:0] with zeros above it, `rtr_o` is frame bit 12, and frame bit 14 is accepted with either value.
- R5: IDE = 1 selects the extended format. Then `ext_o`=1, `id_o` = base identifier shifted left by 18, ORed with the 18-bit extension taken from frame bits 14 to 31. `rtr_o` is frame bit 32, and bits 33 and 34 are accepted with either value.
- R6: The 4-bit length code (MSB first) is reported unchanged on `dlc_o`. The payload holds min(code, 8) bytes, and no bytes when `rtr_o`=1.
- R7: Payload byte i arrives MSB first and appears on `data_o[8i+7:8i]`. Bytes that were not received read as 0.
- R8: The 15 bits after the payload are reported MSB first on `crc_o`. `ack_o`=1 when the acknowledge slot bit (two bits after the checksum) is dominant (0).
- R9: A dominant bit on the checksum delimiter, on the acknowledge delimiter or on any of the 7 end-of-frame bits gives a one-cycle `form_err_o` pulse in the cycle after its strobe. Parsing continues.
- R10: `eof_o` pulses for one cycle in the cycle after the strobe of the seventh end-of-frame bit. All field outputs take the new frame's values in that same cycle and keep them until the next `eof_o`.
- R11: `done_o` pulses for one cycle in the cycle after the third intermission bit, whatever the values of the intermission bits. The next strobed bit is then the start bit of a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_vld_i | input | 1 | Strobe: one destuffed frame bit this cycle |
| bit_val_i | input | 1 | Bit value (0 dominant, 1 recessive) |
| id_o | output | 29 | Identifier (11-bit or 29-bit) |
| ext_o | output | 1 | Extended format flag |
| rtr_o | output | 1 | Remote frame flag |
| dlc_o | output | 4 | Length code as received |
| data_o | output | 64 | Payload, byte i at bits [8i+7:8i] |
| crc_o | output | 15 | Received checksum field |
| ack_o | output | 1 | Acknowledge slot was dominant |
| eof_o | output | 1 | Pulse: frame complete, fields updated |
| done_o | output | 1 | Pulse: intermission over, parser idle |
| sof_warn_o | output | 1 | Pulse: start bit was recessive |
| id_warn_o | output | 1 | Pulse: ID[10:4] all recessive |
| form_err_o | output | 1 | Pulse: dominant delimiter or end-of-frame bit |

## Verification
The bench sends several frames. A length code of 12 checks clamping: a design that does not clamp would keep reading data bits past the real payload, and its checksum and end-of-frame positions would slide. A remote frame with a nonzero code is sent as well, and a design that ignored the remote flag would swallow the checksum as data. Extended frames with idle gaps between strobes, where `bit_val_i` is inverted, catch a design that counts unqualified cycles or latches those values. Other frames carry a recessive start bit with an all-recessive identifier head, or a dominant delimiter or end-of-frame bit. Those frames check that each pulse lands in the exact cycle, because a shifted counter would move the pulse or drop it.

// File: rtl/can_fp_pkg.sv
package can_fp_pkg;
    localparam int BASE_ID_W = 11;
    localparam int EXT_ID_W  = 18;
    localparam int FULL_ID_W = BASE_ID_W + EXT_ID_W;
    localparam int DLC_W     = 4;
    localparam int CRC_W     = 15;
    localparam int EOF_BITS  = 7;
    localparam int IFS_BITS  = 3;
    localparam int WARN_BITS = 7;
    localparam int CNT_W     = 7;

    typedef enum logic [4:0] {
        S_IDLE,
        S_BASE,
        S_RTR_SRR,
        S_IDE,
        S_STD_RB0,
        S_EXT_ID,
        S_EXT_RTR,
        S_EXT_RB1,
        S_EXT_RB0,
        S_DLC,
        S_DATA,
        S_CRC,
        S_CRC_DEL,
        S_ACK,
        S_ACK_DEL,
        S_EOF,
        S_IFS
    } fp_state_e;
endpackage

// File: rtl/can_fp_seq.sv
module can_fp_seq
    import can_fp_pkg::*;
#(
    parameter int MAX_BYTES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bit_vld_i,
    input  logic                  bit_val_i,
    input  logic [DLC_W-2:0]      dlc_head_i,
    input  logic                  rtr_work_i,
    output fp_state_e             state_o,
    output logic [CNT_W-1:0]      cnt_o
);
    fp_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] last_q, last_d;
    logic [DLC_W-1:0] dlc_next;
    logic [CNT_W-1:0] nbytes;

    always_comb begin
        dlc_next = {dlc_head_i, bit_val_i};
        if (rtr_work_i)
            nbytes = '0;
        else if (int'(dlc_next) > MAX_BYTES)
            nbytes = CNT_W'(MAX_BYTES);
        else
            nbytes = CNT_W'(dlc_next);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            last_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            last_q  <= last_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        last_d  = last_q;
        if (bit_vld_i) begin
            cnt_d = cnt_q + 1'b1;
            unique case (state_q)
                S_IDLE: begin
                    state_d = S_BASE;
                    cnt_d   = '0;
                end
                S_BASE: if (cnt_q == CNT_W'(BASE_ID_W - 1)) begin
                    state_d = S_RTR_SRR;
                    cnt_d   = '0;
                end
                S_RTR_SRR: state_d = S_IDE;
                S_IDE: begin
                    state_d = bit_val_i ? S_EXT_ID : S_STD_RB0;
                    cnt_d   = '0;
                end
                S_STD_RB0: begin
                    state_d = S_DLC;
                    cnt_d   = '0;
                end
                S_EXT_ID: if (cnt_q == CNT_W'(EXT_ID_W - 1)) begin
                    state_d = S_EXT_RTR;
                    cnt_d   = '0;
                end
                S_EXT_RTR: state_d = S_EXT_RB1;
                S_EXT_RB1: state_d = S_EXT_RB0;
                S_EXT_RB0: begin
                    state_d = S_DLC;
                    cnt_d   = '0;
                end
                S_DLC: if (cnt_q == CNT_W'(DLC_W - 1)) begin
                    cnt_d   = '0;
                    last_d  = (nbytes << 3) - 1'b1;
                    state_d = (nbytes == '0) ? S_CRC : S_DATA;
                end
                S_DATA: if (cnt_q == last_q) begin
                    state_d = S_CRC;
                    cnt_d   = '0;
                end
                S_CRC: if (cnt_q == CNT_W'(CRC_W - 1)) begin
                    state_d = S_CRC_DEL;
                    cnt_d   = '0;
                end
                S_CRC_DEL: state_d = S_ACK;
                S_ACK:     state_d = S_ACK_DEL;
                S_ACK_DEL: begin
                    state_d = S_EOF;
                    cnt_d   = '0;
                end
                S_EOF: if (cnt_q == CNT_W'(EOF_BITS - 1)) begin
                    state_d = S_IFS;
                    cnt_d   = '0;
                end
                S_IFS: if (cnt_q == CNT_W'(IFS_BITS - 1)) begin
                    state_d = S_IDLE;
                    cnt_d   = '0;
                end
                default: begin
                    state_d = S_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    assign state_o = state_q;
    assign cnt_o   = cnt_q;

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld_i |=> ($stable(state_q) && $stable(cnt_q)));

    p_sof_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld_i && state_q == S_IDLE) |=> (state_q == S_BASE && cnt_q == '0));

    p_base_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BASE) |-> (cnt_q < CNT_W'(BASE_ID_W)));

    p_ifs_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld_i && state_q == S_IFS && cnt_q == CNT_W'(IFS_BITS - 1)) |=> (state_q == S_IDLE));
endmodule

// File: rtl/can_fp_capture.sv
module can_fp_capture
    import can_fp_pkg::*;
#(
    parameter int MAX_BYTES = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bit_vld_i,
    input  logic                    bit_val_i,
    input  fp_state_e               state_i,
    input  logic [CNT_W-1:0]        cnt_i,
    output logic [DLC_W-1:0]        dlc_work_o,
    output logic                    rtr_work_o,
    output logic [FULL_ID_W-1:0]    id_o,
    output logic                    ext_o,
    output logic                    rtr_o,
    output logic [DLC_W-1:0]        dlc_o,
    output logic [MAX_BYTES*8-1:0]  data_o,
    output logic [CRC_W-1:0]        crc_o,
    output logic                    ack_o,
    output logic                    eof_o,
    output logic                    done_o,
    output logic                    sof_warn_o,
    output logic                    id_warn_o,
    output logic                    form_err_o
);
    localparam int DATA_W = MAX_BYTES * 8;
    localparam int POS_W  = $clog2(DATA_W);

    logic [FULL_ID_W-1:0] id_w;
    logic                 ext_w, rtr_w, ack_w;
    logic [DLC_W-1:0]     dlc_w;
    logic [DATA_W-1:0]    data_w;
    logic [CRC_W-1:0]     crc_w;
    logic [POS_W-1:0]     data_pos;
    logic                 last_eof, last_ifs, trailer_bit;

    assign data_pos    = {cnt_i[POS_W-1:3], ~cnt_i[2:0]};
    assign last_eof    = (state_i == S_EOF) && (cnt_i == CNT_W'(EOF_BITS - 1));
    assign last_ifs    = (state_i == S_IFS) && (cnt_i == CNT_W'(IFS_BITS - 1));
    assign trailer_bit = (state_i == S_CRC_DEL) || (state_i == S_ACK_DEL) || (state_i == S_EOF);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_w   <= '0;
            ext_w  <= 1'b0;
            rtr_w  <= 1'b0;
            ack_w  <= 1'b0;
            dlc_w  <= '0;
            data_w <= '0;
            crc_w  <= '0;
        end else if (bit_vld_i) begin
            unique case (state_i)
                S_IDLE: begin
                    id_w   <= '0;
                    ext_w  <= 1'b0;
                    rtr_w  <= 1'b0;
                    ack_w  <= 1'b0;
                    dlc_w  <= '0;
                    data_w <= '0;
                    crc_w  <= '0;
                end
                S_BASE, S_EXT_ID: id_w <= {id_w[FULL_ID_W-2:0], bit_val_i};
                S_RTR_SRR, S_EXT_RTR: rtr_w <= bit_val_i;
                S_IDE:    ext_w <= bit_val_i;
                S_DLC:    dlc_w <= {dlc_w[DLC_W-2:0], bit_val_i};
                S_DATA:   data_w[data_pos] <= bit_val_i;
                S_CRC:    crc_w <= {crc_w[CRC_W-2:0], bit_val_i};
                S_ACK:    ack_w <= ~bit_val_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_o   <= '0;
            ext_o  <= 1'b0;
            rtr_o  <= 1'b0;
            dlc_o  <= '0;
            data_o <= '0;
            crc_o  <= '0;
            ack_o  <= 1'b0;
        end else if (bit_vld_i && last_eof) begin
            id_o   <= id_w;
            ext_o  <= ext_w;
            rtr_o  <= rtr_w;
            dlc_o  <= dlc_w;
            data_o <= data_w;
            crc_o  <= crc_w;
            ack_o  <= ack_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eof_o      <= 1'b0;
            done_o     <= 1'b0;
            sof_warn_o <= 1'b0;
            id_warn_o  <= 1'b0;
            form_err_o <= 1'b0;
        end else begin
            eof_o      <= bit_vld_i && last_eof;
            done_o     <= bit_vld_i && last_ifs;
            sof_warn_o <= bit_vld_i && (state_i == S_IDLE) && bit_val_i;
            id_warn_o  <= bit_vld_i && (state_i == S_BASE) && bit_val_i
                          && (cnt_i == CNT_W'(WARN_BITS - 1)) && (&id_w[WARN_BITS-2:0]);
            form_err_o <= bit_vld_i && trailer_bit && !bit_val_i;
        end
    end

    assign dlc_work_o = dlc_w;
    assign rtr_work_o = rtr_w;

    p_eof_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        eof_o |=> !eof_o);

    p_fields_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !eof_o |-> ($stable(id_o) && $stable(data_o) && $stable(crc_o) && $stable(dlc_o)));

    p_remote_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eof_o && rtr_o) |-> (data_o == '0));

    p_form_in_trailer_r9: assert property (@(posedge clk) disable iff (!rst_n)
        form_err_o |-> ($past(state_i) == S_CRC_DEL || $past(state_i) == S_ACK_DEL
                        || $past(state_i) == S_EOF));

    p_done_alone_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!eof_o && !form_err_o));
endmodule

// File: rtl/can_frame_parser.sv
module can_frame_parser
    import can_fp_pkg::*;
#(
    parameter int MAX_BYTES = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bit_vld_i,
    input  logic                    bit_val_i,
    output logic [28:0]             id_o,
    output logic                    ext_o,
    output logic                    rtr_o,
    output logic [3:0]              dlc_o,
    output logic [MAX_BYTES*8-1:0]  data_o,
    output logic [14:0]             crc_o,
    output logic                    ack_o,
    output logic                    eof_o,
    output logic                    done_o,
    output logic                    sof_warn_o,
    output logic                    id_warn_o,
    output logic                    form_err_o
);
    fp_state_e        state;
    logic [CNT_W-1:0] cnt;
    logic [DLC_W-1:0] dlc_work;
    logic             rtr_work;

    can_fp_seq #(.MAX_BYTES(MAX_BYTES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_vld_i  (bit_vld_i),
        .bit_val_i  (bit_val_i),
        .dlc_head_i (dlc_work[DLC_W-2:0]),
        .rtr_work_i (rtr_work),
        .state_o    (state),
        .cnt_o      (cnt)
    );

    can_fp_capture #(.MAX_BYTES(MAX_BYTES)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_vld_i  (bit_vld_i),
        .bit_val_i  (bit_val_i),
        .state_i    (state),
        .cnt_i      (cnt),
        .dlc_work_o (dlc_work),
        .rtr_work_o (rtr_work),
        .id_o       (id_o),
        .ext_o      (ext_o),
        .rtr_o      (rtr_o),
        .dlc_o      (dlc_o),
        .data_o     (data_o),
        .crc_o      (crc_o),
        .ack_o      (ack_o),
        .eof_o      (eof_o),
        .done_o     (done_o),
        .sof_warn_o (sof_warn_o),
        .id_warn_o  (id_warn_o),
        .form_err_o (form_err_o)
    );
endmodule

// File: tb/can_frame_parser_tb.sv
module can_frame_parser_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_vld = 1'b0;
    logic        bit_val = 1'b0;
    logic [28:0] id_o;
    logic        ext_o, rtr_o, ack_o, eof_o, done_o, sof_warn_o, id_warn_o, form_err_o;
    logic [3:0]  dlc_o;
    logic [63:0] data_o;
    logic [14:0] crc_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    // expected outputs
    logic [28:0] x_id = '0;
    logic        x_ext = 0, x_rtr = 0, x_ack = 0;
    logic [3:0]  x_dlc = '0;
    logic [63:0] x_data = '0;
    logic [14:0] x_crc = '0;
    logic [4:0]  x_ev = '0;   // [0] sof warn [1] id warn [2] form [3] eof [4] done
    // values of the frame being sent
    logic [28:0] p_id;
    logic        p_ext, p_rtr, p_ack;
    logic [3:0]  p_dlc;
    logic [63:0] p_data;
    logic [14:0] p_crc;

    logic       bq[$];
    logic [4:0] eq[$];

    always #4 clk = ~clk;

    can_frame_parser u_dut (
        .clk(clk), .rst_n(rst_n), .bit_vld_i(bit_vld), .bit_val_i(bit_val),
        .id_o(id_o), .ext_o(ext_o), .rtr_o(rtr_o), .dlc_o(dlc_o), .data_o(data_o),
        .crc_o(crc_o), .ack_o(ack_o), .eof_o(eof_o), .done_o(done_o),
        .sof_warn_o(sof_warn_o), .id_warn_o(id_warn_o), .form_err_o(form_err_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic compare_all();
        chk(id_o == x_id,             "R4 R5 id_o",     64'(id_o), 64'(x_id));
        chk(ext_o == x_ext,           "R4 ext_o",       64'(ext_o), 64'(x_ext));
        chk(rtr_o == x_rtr,           "R5 rtr_o",       64'(rtr_o), 64'(x_rtr));
        chk(dlc_o == x_dlc,           "R6 dlc_o",       64'(dlc_o), 64'(x_dlc));
        chk(data_o == x_data,         "R6 R7 data_o",   data_o, x_data);
        chk(crc_o == x_crc,           "R8 crc_o",       64'(crc_o), 64'(x_crc));
        chk(ack_o == x_ack,           "R8 ack_o",       64'(ack_o), 64'(x_ack));
        chk(sof_warn_o == x_ev[0],    "R2 sof_warn_o",  64'(sof_warn_o), 64'(x_ev[0]));
        chk(id_warn_o == x_ev[1],     "R3 id_warn_o",   64'(id_warn_o), 64'(x_ev[1]));
        chk(form_err_o == x_ev[2],    "R9 form_err_o",  64'(form_err_o), 64'(x_ev[2]));
        chk(eof_o == x_ev[3],         "R10 eof_o",      64'(eof_o), 64'(x_ev[3]));
        chk(done_o == x_ev[4],        "R11 done_o",     64'(done_o), 64'(x_ev[4]));
    endtask

    // one clock: check outputs, then drive this cycle's input and predict
    task automatic step(input logic vld, input logic val, input logic [4:0] ev);
        @(negedge clk);
        compare_all();
        bit_vld = vld;
        bit_val = val;
        x_ev = vld ? ev : 5'b0;
        if (vld && ev[3]) begin
            x_id = p_id; x_ext = p_ext; x_rtr = p_rtr; x_dlc = p_dlc;
            x_data = p_data; x_crc = p_crc; x_ack = p_ack;
        end
    endtask

    task automatic push(input logic b, input logic [4:0] e);
        bq.push_back(b);
        eq.push_back(e);
    endtask

    task automatic run_frame(input logic ext, input logic [10:0] base, input logic [17:0] xid,
                             input logic rtr, input logic [3:0] dlc, input logic [63:0] dat,
                             input logic [14:0] crc, input logic ack, input logic sof_bad,
                             input int bad_pos, input int gap, input logic rsv);
        int n;
        bq.delete();
        eq.delete();
        n = rtr ? 0 : ((dlc > 8) ? 8 : int'(dlc));
        push(sof_bad, {4'b0, sof_bad});
        for (int i = 10; i >= 0; i--)
            push(base[i], {3'b0, (i == 4 && base[10:4] == 7'h7F), 1'b0});
        push(ext ? 1'b1 : rtr, 5'b0);
        push(ext, 5'b0);
        if (ext) begin
            for (int i = 17; i >= 0; i--) push(xid[i], 5'b0);
            push(rtr, 5'b0);
            push(rsv, 5'b0);
            push(~rsv, 5'b0);
        end else begin
            push(rsv, 5'b0);
        end
        for (int i = 3; i >= 0; i--) push(dlc[i], 5'b0);
        for (int b = 0; b < n; b++)
            for (int i = 7; i >= 0; i--) push(dat[8*b+i], 5'b0);
        for (int i = 14; i >= 0; i--) push(crc[i], 5'b0);
        for (int t = 0; t < 9; t++) begin
            logic v;
            v = (t == bad_pos) ? 1'b0 : 1'b1;
            push(v, {1'b0, (t == 8), ~v, 2'b0});
            if (t == 0) push(~ack, 5'b0);
        end
        push(1'b1, 5'b0);
        push(rsv, 5'b0);
        push(1'b1, 5'b10000);
        p_ext = ext;
        p_id = ext ? {base, xid} : {18'b0, base};
        p_rtr = rtr;
        p_dlc = dlc;
        p_data = '0;
        for (int b = 0; b < n; b++) p_data[8*b +: 8] = dat[8*b +: 8];
        p_crc = crc;
        p_ack = ack;
        for (int k = 0; k < bq.size(); k++) begin
            for (int g = 0; g < gap; g++) step(1'b0, ~bq[k], 5'b0);
            step(1'b1, bq[k], eq[k]);
        end
        step(1'b0, 1'b0, 5'b0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: all outputs zero after reset
        chk({id_o, dlc_o, crc_o} == '0, "R1 fields zero", 64'({id_o, dlc_o, crc_o}), 64'(0));
        chk(data_o == '0, "R1 data zero", data_o, 64'(0));
        chk({ext_o, rtr_o, ack_o, eof_o, done_o, sof_warn_o, id_warn_o, form_err_o} == '0,
            "R1 flags zero", 64'({ext_o, rtr_o, ack_o, eof_o, done_o, sof_warn_o, id_warn_o, form_err_o}), 64'(0));
        // base data frame, 2 bytes, acked
        run_frame(0, 11'h123, 18'h0, 0, 4'd2, 64'h0000_0000_0000_A55A, 15'h1B2C, 1, 0, -1, 0, 0);
        // extended, 8 bytes, idle gaps with inverted value (R2), nack
        run_frame(1, 11'h5A1, 18'h2C3D5, 0, 4'd8, 64'h0123_4567_89AB_CDEF, 15'h7FFF, 0, 0, -1, 2, 1);
        // base remote frame with nonzero length code (R6)
        run_frame(0, 11'h0F0, 18'h0, 1, 4'd4, 64'hFFFF_FFFF_FFFF_FFFF, 15'h0001, 1, 0, -1, 0, 1);
        // length code above 8 clamps (R6)
        run_frame(0, 11'h001, 18'h0, 0, 4'd12, 64'hDEAD_BEEF_CAFE_F00D, 15'h4321, 1, 0, -1, 1, 0);
        // recessive start bit, ID[10:4] recessive, extended remote (R2 R3 R5)
        run_frame(1, 11'h7F0, 18'h3FFFF, 1, 4'd1, 64'h0, 15'h2AAA, 1, 1, -1, 0, 0);
        // dominant CRC delimiter (R9)
        run_frame(0, 11'h333, 18'h0, 0, 4'd1, 64'h77, 15'h1111, 1, 0, 0, 0, 0);
        // dominant ACK delimiter (R9)
        run_frame(1, 11'h444, 18'h155AA, 0, 4'd3, 64'h0000_0000_0012_3456, 15'h5555, 0, 0, 1, 0, 1);
        // dominant last end-of-frame bit (R9 R10)
        run_frame(0, 11'h222, 18'h0, 0, 4'd0, 64'h0, 15'h0F0F, 1, 0, 8, 1, 0);
        // empty payload and back-to-back restart (R11)
        run_frame(0, 11'h7FF, 18'h0, 0, 4'd0, 64'h0, 15'h6789, 0, 0, 4, 0, 1);
        repeat (3) step(1'b0, 1'b1, 5'b0);
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule